// File: doc/BRIEF.md
# Sixteen-Port I/O Instruction Unit

This block executes the I/O class of a 16-bit instruction set. It moves one word between the processor's register file and one of sixteen external 16-bit ports. An instruction is handed over on a valid/ready pair. The unit reads or writes the register file through its own read and write ports. It addresses the outside world with a 4-bit port number, a read strobe and a write strobe. The port number comes from one of two places, chosen by a single instruction bit: an immediate nibble carried in the instruction, or a 4-bit port-address register held inside the unit. A third form of the instruction loads that port-address register from the low nibble of a general register.

Control is a four-state machine. `ST_IDLE` accepts instructions. `ST_OUT` drives one word onto a port. `ST_IN` samples a port into a register. `ST_LDA` loads the port-address register. Transitions:
- `IDLE→OUT`: an accepted OUT.
- `IDLE→IN`: an accepted IN.
- `IDLE→LDA`: an accepted address load.
- `IDLE→IDLE`: no valid instruction, or an accepted instruction outside the I/O class.
- `OUT→IDLE`, `IN→IDLE` and `LDA→IDLE`: taken unconditionally after one cycle.

Every I/O instruction therefore occupies exactly one cycle after its acceptance.

Instruction fields use `ins_word[15:0]`:
- `[15]` must be 0.
- `[14:13]` must be `11` for the I/O class.
- `[12]` selects the addressing mode: 0 immediate, 1 port-address register.
- `[11]` selects the direction: 0 IN, 1 OUT.
- `[10]` set means an address load.
- `[9:8]` are unused.
- `[7:4]` hold the immediate port number.
- `[3:0]` hold the register number.

Top module: `pio_exec_unit`

## Requirements
- R1: After reset `ins_ready` is 1, both strobes and `rf_wr_en` are 0, and the port-address register holds 0, so an indirect OUT issued first goes to port 0.
- R2: An OUT (`[15]`=0, `[14:13]`=11, `[10]`=0, `[11]`=1) accepted at a clock edge drives `port_wr_stb` high for exactly the following cycle. During that cycle it drives `port_addr` to the selected port and `port_wr_data` to the word of register `[3:0]`. `port_rd_stb` is never high in the same cycle as `port_wr_stb`.
- R3: An IN (`[10]`=0, `[11]`=0) accepted at an edge raises `port_rd_stb` with `port_addr` for exactly the following cycle. In that same cycle it presents `rf_wr_en`=1, `rf_wr_addr`=`[3:0]` and `rf_wr_data` equal to `port_rd_data`, so the register takes the port word at the edge closing that cycle.
- R4: With `[12]`=1 the port number is the current content of the port-address register; with `[12]`=0 it is `[7:4]`.
- R5: An address load (`[10]`=1) copies bits [3:0] of register `[3:0]` into the port-address register and raises neither strobe nor `rf_wr_en`. Bits `[12]`, `[11]` and `[7:4]` have no effect on it.
- R6: An accepted word with `[15]`=1 or `[14:13]`≠11 raises no strobe and no register write, leaves `ins_ready` at 1, and leaves the port-address register unchanged.
- R7: `ins_ready` is 0 during the execution cycle of every I/O instruction. A word held on `ins_word` with `ins_valid`=1 during that cycle is accepted only at the next edge and executes once.
- R8: Whenever neither strobe is high, `port_addr` and `port_wr_data` are 0 and `rf_wr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_valid | input | 1 | Instruction word present |
| ins_word | input | 16 | Instruction word |
| ins_ready | output | 1 | Unit can accept an instruction this cycle |
| rf_rd_addr | output | REG_AW (4) | Register-file read address |
| rf_rd_data | input | DATA_W (16) | Register-file read data (combinational) |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_wr_addr | output | REG_AW (4) | Register-file write address |
| rf_wr_data | output | DATA_W (16) | Register-file write data |
| port_addr | output | PORT_AW (4) | Selected port number |
| port_rd_stb | output | 1 | One-cycle port read strobe |
| port_rd_data | input | DATA_W (16) | Word returned by the addressed port |
| port_wr_stb | output | 1 | One-cycle port write strobe |
| port_wr_data | output | DATA_W (16) | Word sent to the addressed port |

## Verification
The bench builds the unit with its defaults: 16-bit data, a 4-bit port number and a 4-bit register number. At these values every one of the sixteen ports and registers is reachable from both addressing modes. This allows a full sweep of immediate port numbers. It also allows the port-address register to be loaded with the extreme values 0 and 15. All-ones and mixed data patterns travel both ways, and IN results are read back through later OUTs. Instructions are issued back to back, so every execution cycle also sees a pending word held against a low `ins_ready`.

// File: rtl/pio_pkg.sv
package pio_pkg;

    // instruction field positions (bit 15 is the class bit)
    localparam int INS_W      = 16;
    localparam int F_CLASS0   = 15;
    localparam int F_GRP_HI   = 14;
    localparam int F_GRP_LO   = 13;
    localparam int F_MODE     = 12;
    localparam int F_DIR      = 11;
    localparam int F_LDA      = 10;
    localparam int F_PORT_LO  = 4;
    localparam int F_REG_LO   = 0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OUT  = 2'd1,
        ST_IN   = 2'd2,
        ST_LDA  = 2'd3
    } pio_state_t;

    typedef struct packed {
        logic       is_io;
        logic       set_addr;
        logic       indirect;
        logic       dir_out;
        logic [3:0] imm_port;
        logic [3:0] reg_sel;
    } pio_dec_t;

endpackage

// File: rtl/pio_decode.sv
module pio_decode
    import pio_pkg::*;
(
    input  logic [INS_W-1:0] word,
    output pio_dec_t         dec
);
    always_comb begin
        dec.is_io    = !word[F_CLASS0] && word[F_GRP_HI] && word[F_GRP_LO];
        dec.set_addr = word[F_LDA];
        dec.indirect = word[F_MODE];
        dec.dir_out  = word[F_DIR];
        dec.imm_port = word[F_PORT_LO +: 4];
        dec.reg_sel  = word[F_REG_LO +: 4];
    end
endmodule

// File: rtl/pio_addr_reg.sv
module pio_addr_reg #(
    parameter int PORT_AW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [PORT_AW-1:0] d,
    output logic [PORT_AW-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/pio_fsm.sv
module pio_fsm
    import pio_pkg::*;
#(
    parameter int PORT_AW = 4,
    parameter int REG_AW  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ins_valid,
    input  pio_dec_t           dec,
    output logic               ready,
    output logic               rd_stb,
    output logic               wr_stb,
    output logic               lda_en,
    output logic               cur_indirect,
    output logic [PORT_AW-1:0] cur_port,
    output logic [REG_AW-1:0]  cur_reg
);
    pio_state_t state, state_nx;
    logic       accept;

    assign accept = ins_valid && (state == ST_IDLE);

    always_comb begin
        state_nx = ST_IDLE;
        unique case (state)
            ST_IDLE: begin
                if (accept && dec.is_io) begin
                    if (dec.set_addr)     state_nx = ST_LDA;
                    else if (dec.dir_out) state_nx = ST_OUT;
                    else                  state_nx = ST_IN;
                end
            end
            ST_OUT:  state_nx = ST_IDLE;
            ST_IN:   state_nx = ST_IDLE;
            ST_LDA:  state_nx = ST_IDLE;
        endcase
    end

    // state register and latched operand fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            cur_indirect <= 1'b0;
            cur_port     <= '0;
            cur_reg      <= '0;
        end else begin
            state <= state_nx;
            if (accept && dec.is_io) begin
                cur_indirect <= dec.indirect;
                cur_port     <= dec.imm_port[PORT_AW-1:0];
                cur_reg      <= dec.reg_sel[REG_AW-1:0];
            end
        end
    end

    // per-state outputs
    always_comb begin
        ready  = 1'b0;
        rd_stb = 1'b0;
        wr_stb = 1'b0;
        lda_en = 1'b0;
        unique case (state)
            ST_IDLE: ready  = 1'b1;
            ST_OUT:  wr_stb = 1'b1;
            ST_IN:   rd_stb = 1'b1;
            ST_LDA:  lda_en = 1'b1;
        endcase
    end
endmodule

// File: rtl/pio_exec_unit.sv
module pio_exec_unit
    import pio_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int PORT_AW = 4,
    parameter int REG_AW  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ins_valid,
    input  logic [15:0]        ins_word,
    output logic               ins_ready,
    output logic [REG_AW-1:0]  rf_rd_addr,
    input  logic [DATA_W-1:0]  rf_rd_data,
    output logic               rf_wr_en,
    output logic [REG_AW-1:0]  rf_wr_addr,
    output logic [DATA_W-1:0]  rf_wr_data,
    output logic [PORT_AW-1:0] port_addr,
    output logic               port_rd_stb,
    input  logic [DATA_W-1:0]  port_rd_data,
    output logic               port_wr_stb,
    output logic [DATA_W-1:0]  port_wr_data
);
    localparam int NPORTS = 1 << PORT_AW;

    pio_dec_t           dec;
    logic               rd_stb, wr_stb, lda_en, cur_indirect;
    logic [PORT_AW-1:0] cur_port, ior_q, sel_port;
    logic [REG_AW-1:0]  cur_reg;

    pio_decode u_dec (
        .word (ins_word),
        .dec  (dec)
    );

    pio_fsm #(.PORT_AW(PORT_AW), .REG_AW(REG_AW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ins_valid    (ins_valid),
        .dec          (dec),
        .ready        (ins_ready),
        .rd_stb       (rd_stb),
        .wr_stb       (wr_stb),
        .lda_en       (lda_en),
        .cur_indirect (cur_indirect),
        .cur_port     (cur_port),
        .cur_reg      (cur_reg)
    );

    pio_addr_reg #(.PORT_AW(PORT_AW)) u_ior (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (lda_en),
        .d     (rf_rd_data[PORT_AW-1:0]),
        .q     (ior_q)
    );

    assign sel_port = cur_indirect ? ior_q : cur_port;

    always_comb begin
        rf_rd_addr   = cur_reg;
        rf_wr_addr   = cur_reg;
        rf_wr_en     = rd_stb;
        rf_wr_data   = rd_stb ? port_rd_data : '0;
        port_rd_stb  = rd_stb;
        port_wr_stb  = wr_stb;
        port_addr    = (rd_stb || wr_stb) ? sel_port : '0;
        port_wr_data = wr_stb ? rf_rd_data : '0;
    end

    initial begin
        if (NPORTS > 16 || REG_AW > 4)
            $error("pio_exec_unit: fields exceed instruction nibbles");
    end
endmodule

// File: rtl/pio_exec_unit_chk.sv
module pio_exec_unit_chk #(
    parameter int DATA_W  = 16,
    parameter int PORT_AW = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ins_valid,
    input logic [15:0]        ins_word,
    input logic               ins_ready,
    input logic               rf_wr_en,
    input logic [PORT_AW-1:0] port_addr,
    input logic               port_rd_stb,
    input logic               port_wr_stb,
    input logic [DATA_W-1:0]  port_wr_data
);
    logic acc, acc_io, acc_nonio;
    assign acc       = ins_valid && ins_ready;
    assign acc_io    = acc && !ins_word[15] && (ins_word[14:13] == 2'b11);
    assign acc_nonio = acc && !acc_io;

    p_out_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_io && !ins_word[10] && ins_word[11]) |=> (port_wr_stb && !port_rd_stb));
    p_out_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr_stb |=> !port_wr_stb);
    p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_wr_stb && port_rd_stb));
    p_in_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_io && !ins_word[10] && !ins_word[11]) |=> (port_rd_stb && rf_wr_en));
    p_in_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        port_rd_stb |=> !port_rd_stb);
    p_lda_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_io && ins_word[10]) |=> (!port_rd_stb && !port_wr_stb && !rf_wr_en && !ins_ready));
    p_nonio_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_nonio |=> (!port_rd_stb && !port_wr_stb && !rf_wr_en && ins_ready));
    p_busy_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_ready |=> ins_ready);
    p_idle_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_rd_stb && !port_wr_stb) |-> (port_addr == '0 && port_wr_data == '0 && !rf_wr_en));
endmodule

bind pio_exec_unit pio_exec_unit_chk #(.DATA_W(DATA_W), .PORT_AW(PORT_AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ins_valid    (ins_valid),
    .ins_word     (ins_word),
    .ins_ready    (ins_ready),
    .rf_wr_en     (rf_wr_en),
    .port_addr    (port_addr),
    .port_rd_stb  (port_rd_stb),
    .port_wr_stb  (port_wr_stb),
    .port_wr_data (port_wr_data)
);

// File: tb/pio_exec_unit_test.sv
module pio_exec_unit_test;
    localparam int DW = 16;
    localparam int AW = 4;
    localparam int RW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ins_valid = 1'b0;
    logic [15:0]   ins_word = '0;
    logic          ins_ready;
    logic [RW-1:0] rf_rd_addr, rf_wr_addr;
    logic [DW-1:0] rf_rd_data, rf_wr_data;
    logic          rf_wr_en;
    logic [AW-1:0] port_addr;
    logic          port_rd_stb, port_wr_stb;
    logic [DW-1:0] port_rd_data, port_wr_data;

    always #10 clk = ~clk;   // 50 MHz

    pio_exec_unit #(.DATA_W(DW), .PORT_AW(AW), .REG_AW(RW)) uut (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_word(ins_word),
        .ins_ready(ins_ready), .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
        .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data),
        .port_addr(port_addr), .port_rd_stb(port_rd_stb), .port_rd_data(port_rd_data),
        .port_wr_stb(port_wr_stb), .port_wr_data(port_wr_data)
    );

    // register file and port devices
    logic [DW-1:0] rf [16];
    logic [DW-1:0] exp_rf [16];
    logic [DW-1:0] port_val [16];
    logic [3:0]    exp_ior;

    assign rf_rd_data   = rf[rf_rd_addr];
    assign port_rd_data = port_val[port_addr];

    always @(posedge clk) if (rf_wr_en) rf[rf_wr_addr] <= rf_wr_data;

    typedef struct {
        bit         is_out;
        logic [3:0] addr;
        logic [DW-1:0] data;
        logic [3:0] rsel;
    } exp_t;
    exp_t sb[$];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [15:0] mk(input bit mode, input bit dir, input bit lda,
                                       input logic [3:0] p, input logic [3:0] r);
        return {1'b0, 2'b11, mode, dir, lda, 2'b00, p, r};
    endfunction

    // drive one word; returns at the negedge of the cycle after acceptance
    task automatic drive(input logic [15:0] w);
        ins_valid = 1'b1;
        ins_word  = w;
        while (!ins_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic issue_io(input bit mode, input bit dir, input bit lda,
                            input logic [3:0] p, input logic [3:0] r, input string req);
        exp_t e;
        logic [3:0] a;
        a = mode ? exp_ior : p;
        if (lda) begin
            exp_ior = exp_rf[r][3:0];
        end else if (dir) begin
            e.is_out = 1; e.addr = a; e.data = exp_rf[r]; e.rsel = r;
            sb.push_back(e);
        end else begin
            e.is_out = 0; e.addr = a; e.data = port_val[a]; e.rsel = r;
            sb.push_back(e);
            exp_rf[r] = port_val[a];
        end
        drive(mk(mode, dir, lda, p, r));
        chk(ins_ready == 1'b0, "R7", {req, " ready in execution cycle"}, 32'(ins_ready), 0);
    endtask

    task automatic issue_other(input logic [15:0] w);
        drive(w);
        chk(ins_ready == 1'b1, "R6", "ready after non-I/O word", 32'(ins_ready), 1);
        chk(!port_rd_stb && !port_wr_stb && !rf_wr_en, "R6", "strobes after non-I/O word",
            {29'd0, port_rd_stb, port_wr_stb, rf_wr_en}, 0);
    endtask

    task automatic go_idle();
        ins_valid = 1'b0;
        ins_word  = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // monitor: scoreboard pop and idle-bus checks
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (port_wr_stb || port_rd_stb) begin
                chk(!(port_wr_stb && port_rd_stb), "R2", "both strobes", 32'(port_rd_stb), 0);
                if (sb.size() == 0) begin
                    chk(0, "R6", "unexpected strobe, port", 32'(port_addr), 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(port_wr_stb == e.is_out, e.is_out ? "R2" : "R3", "strobe kind",
                        32'(port_wr_stb), 32'(e.is_out));
                    chk(port_addr == e.addr, "R4", "port_addr", 32'(port_addr), 32'(e.addr));
                    if (e.is_out) begin
                        chk(port_wr_data == e.data, "R2", "port_wr_data",
                            32'(port_wr_data), 32'(e.data));
                    end else begin
                        chk(rf_wr_en && rf_wr_addr == e.rsel, "R3", "rf write enable/addr",
                            {27'd0, rf_wr_en, rf_wr_addr}, {27'd0, 1'b1, e.rsel});
                        chk(rf_wr_data == e.data, "R3", "rf_wr_data",
                            32'(rf_wr_data), 32'(e.data));
                    end
                end
            end else begin
                chk(port_addr == '0 && port_wr_data == '0 && !rf_wr_en, "R8", "idle bus",
                    {11'd0, rf_wr_en, port_addr, port_wr_data}, 0);
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            rf[i]       = 16'hA500 ^ (16'(i) * 16'h0111);
            exp_rf[i]   = rf[i];
            port_val[i] = 16'h3C00 + 16'(i) * 16'h0103;
        end
        port_val[15] = 16'hFFFF;
        port_val[0]  = 16'h0000;
        exp_ior = 4'd0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ins_ready == 1'b1, "R1", "ready after reset", 32'(ins_ready), 1);
        chk(!port_rd_stb && !port_wr_stb && !rf_wr_en, "R1", "strobes after reset",
            {29'd0, port_rd_stb, port_wr_stb, rf_wr_en}, 0);

        // R1/R4: indirect OUT uses reset address 0
        issue_io(1, 1, 0, 4'd9, 4'd5, "R1");
        // R2: immediate OUT sweep over all ports, back to back (R7)
        for (int p = 0; p < 16; p++) issue_io(0, 1, 0, 4'(p), 4'(15 - p), "R2");
        go_idle();

        // R3: immediate IN, then read back through OUT
        issue_io(0, 0, 0, 4'd9, 4'd2, "R3");
        issue_io(0, 1, 0, 4'd3, 4'd2, "R3");
        issue_io(0, 0, 0, 4'd15, 4'd7, "R3");
        issue_io(0, 0, 0, 4'd0, 4'd8, "R3");
        issue_io(0, 1, 0, 4'd1, 4'd7, "R3");
        issue_io(0, 1, 0, 4'd2, 4'd8, "R3");
        go_idle();

        // R5: address load (reg 11 low nibble 11); mode/dir/port bits ignored
        issue_io(1, 1, 1, 4'd4, 4'd11, "R5");
        issue_io(1, 1, 0, 4'd0, 4'd4, "R4");
        issue_io(1, 0, 0, 4'd2, 4'd6, "R4");
        issue_io(0, 1, 0, 4'd5, 4'd6, "R4");
        issue_io(0, 0, 1, 4'd9, 4'd15, "R5");
        issue_io(1, 1, 0, 4'd3, 4'd1, "R5");
        issue_io(0, 1, 1, 4'd1, 4'd0, "R5");
        issue_io(1, 0, 0, 4'd15, 4'd9, "R5");
        go_idle();

        // R6: non-I/O words, then confirm address register unchanged
        issue_io(1, 0, 1, 4'd0, 4'd12, "R5");
        issue_other(16'h8000 | mk(1, 1, 0, 4'd7, 4'd3));
        issue_other(16'h0000);
        issue_other(16'h2000 | 16'h1A53);
        issue_other(16'h4000 | 16'h1C21);
        issue_other(16'hE7FF);
        go_idle();
        issue_io(1, 1, 0, 4'd0, 4'd3, "R6");
        go_idle();

        chk(sb.size() == 0, "R2", "scoreboard drained", 32'(sb.size()), 0);
        done = 1;
        summary();
    end
endmodule